// File: doc/BRIEF.md
# Strap-Latched Frequency Select Controller

This block sits beside a clock synthesizer and decides which entry of the synthesizer's frequency table is used. Several pins of the synthesizer serve two purposes. During power-up they are inputs that carry strap levels. After that they drive clocks. The block samples those strap levels exactly once, on the first clock after power-on reset is released. Until that sample is taken, it keeps the output enables of those pins low. After the sample it raises all of the enables, and from then on it ignores the pin levels.

The frequency index is taken from one of two places, chosen by a software select bit. When the bit is 0, the index is the five latched hardware straps with a 0 on top, which gives 32 table entries. When the bit is 1, the index is a six-bit code held in software registers, which gives 64 table entries. The lower 32 software entries are the same as the 32 hardware entries. A latched strap also chooses between the 24 MHz and 48 MHz output.

A second latched strap, the role strap, decides what one shared pin does. When the role strap is 1, the pin is an active-low power-down input and the block raises a power-down request when the pin is low. When the role strap is 0, the pin is an open-drain active-low reset output. In that role a watchdog runs. If the watchdog is not kicked within a set number of cycles, the block pulls the pin low for a set pulse length, which is 4 ms of the 14.318 MHz reference clock by default.

Top module: `fsel_ctrl`

## Requirements
- R1: While `rst` is high, every bit of `strap_oe_o` is 0, `pwrdn_req_o` is 0 and `rst_drv_o` is 0. Also during reset, `freq_idx_o` holds the undriven-strap default code 10 (FS4..FS0 = 0,1,0,1,0) and `sel24_o` holds its default of 1.
- R2: The strap pins are captured at the first rising clock edge with `rst` low, and from that same edge all seven bits of `strap_oe_o` are 1. The bit order of `strap_oe_o` is: bits 4:0 for FS0..FS4, bit 5 for the 24/48 strap, bit 6 for the role strap. After the capture, later changes on the strap pins have no effect on `freq_idx_o`.
- R3: When `sw_mode_i` is 0, `freq_idx_o` equals {1'b0, FS4..FS0} one clock after the sample, with bit i of the index taken from strap FSi.
- R4: When `sw_mode_i` is 1, `freq_idx_o` equals `sw_code_i` one clock later, for all 64 codes. When `sw_mode_i` goes back to 0, the index returns to the latched hardware code.
- R5: `sel24_o` equals the latched 24/48 strap, where 1 selects 24 MHz and 0 selects 48 MHz.
- R6: When the role strap was latched as 1, `pwrdn_req_o` equals the inverse of `pd_pin_i` one clock later. In this role `rst_drv_o` stays 0 whatever the kick input does.
- R7: When the role strap was latched as 0, `pwrdn_req_o` stays 0. The watchdog starts one clock after the sample, and `rst_drv_o` rises `WD_CYCLES` clocks after the last counter reload.
- R8: Each reset pulse holds `rst_drv_o` high for exactly `PULSE_CYCLES` clocks. The watchdog then counts a fresh window of `WD_CYCLES` clocks, so pulses repeat every `WD_CYCLES + PULSE_CYCLES` clocks.
- R9: A kick sampled high reloads the watchdog. Kicks that come more often than every `WD_CYCLES` clocks keep `rst_drv_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| fs_pin_i | input | 5 | Frequency strap levels, bit i = FSi |
| sel24_pin_i | input | 1 | 24/48 strap level |
| mode_pin_i | input | 1 | Shared-pin role strap level |
| pd_pin_i | input | 1 | Shared pin level, read as active-low power-down |
| sw_mode_i | input | 1 | 1 selects the software code |
| sw_code_i | input | 6 | Software frequency code |
| wd_kick_i | input | 1 | Watchdog reload |
| freq_idx_o | output | 6 | Frequency table index |
| sel24_o | output | 1 | 1 = 24 MHz, 0 = 48 MHz |
| strap_oe_o | output | 7 | Output enables of the strap pins |
| pwrdn_req_o | output | 1 | Power-down request |
| rst_drv_o | output | 1 | 1 pulls the open-drain reset pin low |

## Verification
The bench builds the block with `WD_CYCLES` = 20 and `PULSE_CYCLES` = 6. With these values a whole timeout, a whole pulse and the following window take only a few dozen clocks, so the exact edge counts can be measured directly rather than estimated. The short window also makes it cheap to run a full power-up for every one of the 32 hardware codes in both roles, and to sweep all 64 software codes.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int HW_W = 5;
  localparam int SW_W = 6;
  localparam int N_STRAP = HW_W + 2;
  localparam logic [HW_W-1:0] FS_UNDRIVEN = 5'b01010;
  localparam logic SEL24_UNDRIVEN = 1'b1;
  localparam logic ROLE_UNDRIVEN = 1'b1;
  typedef enum logic [1:0] {WD_IDLE, WD_COUNT, WD_PULSE} wd_state_t;
endpackage

// File: rtl/strap_sampler.sv
module strap_sampler
  import fsel_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [HW_W-1:0] fs_pin_i,
  input  logic            sel24_pin_i,
  input  logic            role_pin_i,
  output logic [HW_W-1:0] fs_q,
  output logic            sel24_q,
  output logic            role_q,
  output logic            done_q,
  output logic [N_STRAP-1:0] oe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q    <= FS_UNDRIVEN;
      sel24_q <= SEL24_UNDRIVEN;
      role_q  <= ROLE_UNDRIVEN;
      done_q  <= 1'b0;
    end else if (!done_q) begin
      fs_q    <= fs_pin_i;
      sel24_q <= sel24_pin_i;
      role_q  <= role_pin_i;
      done_q  <= 1'b1;
    end
  end

  // one enable flop per shared pin, released at the capture edge
  for (genvar g = 0; g < N_STRAP; g++) begin : g_oe
    always_ff @(posedge clk) begin
      if (rst) oe_q[g] <= 1'b0;
      else if (!done_q) oe_q[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/freq_index_sel.sv
module freq_index_sel
  import fsel_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sw_mode_i,
  input  logic [SW_W-1:0] sw_code_i,
  input  logic [HW_W-1:0] hw_code_i,
  output logic [SW_W-1:0] idx_q
);
  localparam int PAD_W = SW_W - HW_W;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= {{PAD_W{1'b0}}, FS_UNDRIVEN};
    else if (sw_mode_i) idx_q <= sw_code_i;
    else idx_q <= {{PAD_W{1'b0}}, hw_code_i};
  end
endmodule

// File: rtl/wd_pulse.sv
module wd_pulse
  import fsel_pkg::*;
#(
  parameter int WD_CYCLES    = 1 << 20,
  parameter int PULSE_CYCLES = 57273
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic kick_i,
  output logic drive_o
);
  localparam int MAXC = (WD_CYCLES > PULSE_CYCLES) ? WD_CYCLES : PULSE_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WD_LAST = CW'(WD_CYCLES - 1);
  localparam logic [CW-1:0] PL_LAST = CW'(PULSE_CYCLES - 1);

  wd_state_t state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      state <= WD_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        WD_IDLE: begin
          state <= WD_COUNT;
          cnt   <= '0;
        end
        WD_COUNT: begin
          if (kick_i) cnt <= '0;
          else if (cnt == WD_LAST) begin
            state <= WD_PULSE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        WD_PULSE: begin
          if (cnt == PL_LAST) begin
            state <= WD_COUNT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          state <= WD_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign drive_o = (state == WD_PULSE);
endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
  import fsel_pkg::*;
#(
  parameter int WD_CYCLES    = 1 << 20,
  parameter int PULSE_CYCLES = 57273
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HW_W-1:0]    fs_pin_i,
  input  logic               sel24_pin_i,
  input  logic               mode_pin_i,
  input  logic               pd_pin_i,
  input  logic               sw_mode_i,
  input  logic [SW_W-1:0]    sw_code_i,
  input  logic               wd_kick_i,
  output logic [SW_W-1:0]    freq_idx_o,
  output logic               sel24_o,
  output logic [N_STRAP-1:0] strap_oe_o,
  output logic               pwrdn_req_o,
  output logic               rst_drv_o
);
  logic [HW_W-1:0] hw_code;
  logic            role_q;
  logic            done_q;

  strap_sampler u_samp (
    .clk         (clk),
    .rst         (rst),
    .fs_pin_i    (fs_pin_i),
    .sel24_pin_i (sel24_pin_i),
    .role_pin_i  (mode_pin_i),
    .fs_q        (hw_code),
    .sel24_q     (sel24_o),
    .role_q      (role_q),
    .done_q      (done_q),
    .oe_q        (strap_oe_o)
  );

  freq_index_sel u_sel (
    .clk       (clk),
    .rst       (rst),
    .sw_mode_i (sw_mode_i),
    .sw_code_i (sw_code_i),
    .hw_code_i (hw_code),
    .idx_q     (freq_idx_o)
  );

  wd_pulse #(
    .WD_CYCLES    (WD_CYCLES),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_wd (
    .clk     (clk),
    .rst     (rst),
    .en_i    (done_q && !role_q),
    .kick_i  (wd_kick_i),
    .drive_o (rst_drv_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pwrdn_req_o <= 1'b0;
    else pwrdn_req_o <= done_q && role_q && !pd_pin_i;
  end
endmodule

// File: rtl/fsel_ctrl_chk.sv
module fsel_ctrl_chk
  import fsel_pkg::*;
#(
  parameter int PULSE_CYCLES = 57273
) (
  input logic               clk,
  input logic               rst,
  input logic               role_q,
  input logic               done_q,
  input logic               sw_mode_i,
  input logic [SW_W-1:0]    sw_code_i,
  input logic [SW_W-1:0]    freq_idx_o,
  input logic [N_STRAP-1:0] strap_oe_o,
  input logic               pwrdn_req_o,
  input logic               rst_drv_o
);
  localparam int RW = $clog2(PULSE_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (rst_drv_o) run <= run + 1'b1;
    else run <= '0;
  end

  a_r2_oe_stays: assert property (@(posedge clk) disable iff (rst)
    (strap_oe_o == '1) |=> (strap_oe_o == '1));
  a_r3_hw_top_bit: assert property (@(posedge clk) disable iff (rst)
    (done_q && !sw_mode_i) |=> (freq_idx_o[SW_W-1] == 1'b0));
  a_r4_sw_follow: assert property (@(posedge clk) disable iff (rst)
    sw_mode_i |=> (freq_idx_o == $past(sw_code_i)));
  a_r6_no_drive_pd_role: assert property (@(posedge clk) disable iff (rst)
    role_q |=> !rst_drv_o);
  a_r7_no_pd_reset_role: assert property (@(posedge clk) disable iff (rst)
    !role_q |=> !pwrdn_req_o);
  a_r8_pulse_bound: assert property (@(posedge clk) disable iff (rst)
    rst_drv_o |-> (run < RW'(PULSE_CYCLES)));
endmodule

bind fsel_ctrl fsel_ctrl_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .role_q      (role_q),
  .done_q      (done_q),
  .sw_mode_i   (sw_mode_i),
  .sw_code_i   (sw_code_i),
  .freq_idx_o  (freq_idx_o),
  .strap_oe_o  (strap_oe_o),
  .pwrdn_req_o (pwrdn_req_o),
  .rst_drv_o   (rst_drv_o)
);

// File: tb/fsel_ctrl_bench.sv
module fsel_ctrl_bench;
  localparam int W = 20;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] fs_pin = 5'd0;
  logic sel24_pin = 1'b0, mode_pin = 1'b1, pd_pin = 1'b1;
  logic sw_mode = 1'b0, kick = 1'b0;
  logic [5:0] sw_code = 6'd0;
  logic [5:0] idx;
  logic sel24, pwrdn, drv;
  logic [6:0] oe;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  fsel_ctrl #(.WD_CYCLES(W), .PULSE_CYCLES(P)) u_fsel_ctrl (
    .clk(clk), .rst(rst), .fs_pin_i(fs_pin), .sel24_pin_i(sel24_pin),
    .mode_pin_i(mode_pin), .pd_pin_i(pd_pin), .sw_mode_i(sw_mode),
    .sw_code_i(sw_code), .wd_kick_i(kick), .freq_idx_o(idx),
    .sel24_o(sel24), .strap_oe_o(oe), .pwrdn_req_o(pwrdn), .rst_drv_o(drv)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // power up with given straps; returns after the capture edge (E0)
  task automatic power_up(input logic [4:0] fs, input logic sel, input logic md, input bit chk_rst);
    @(negedge clk);
    rst = 1'b1; fs_pin = fs; sel24_pin = sel; mode_pin = md;
    sw_mode = 1'b0; kick = 1'b0; pd_pin = 1'b1;
    repeat (2) @(negedge clk);
    if (chk_rst) begin
      check(oe == 7'd0, "R1 oe", oe, 0);
      check(idx == 6'd10, "R1 idx", idx, 10);
      check(sel24 == 1'b1, "R1 sel24", sel24, 1);
      check(!pwrdn && !drv, "R1 pwrdn/drv", {pwrdn, drv}, 0);
    end
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin : main
    int n;
    bit quiet;
    // R1..R3, R5 sweep over every hardware code in both roles
    for (int f = 0; f < 32; f++) begin
      for (int m = 0; m < 2; m++) begin
        logic sel;
        sel = logic'(f[0] ^ m[0]);
        power_up(5'(f), sel, logic'(m), (f == 0 || f == 31));
        check(oe == 7'h7f, "R2 oe", oe, 127);
        check(sel24 == sel, "R5 sel24", sel24, sel);
        fs_pin = ~5'(f); sel24_pin = ~sel;
        @(negedge clk);
        check(idx == 6'(f), "R3 idx", idx, f);
        @(negedge clk);
        check(idx == 6'(f) && sel24 == sel, "R2 straps ignored", idx, f);
      end
    end

    // R4 software sweep
    power_up(5'd19, 1'b0, 1'b1, 1'b0);
    sw_mode = 1'b1;
    for (int c = 0; c < 64; c++) begin
      sw_code = 6'(c);
      @(negedge clk);
      check(idx == 6'(c), "R4 sw idx", idx, c);
    end
    sw_mode = 1'b0;
    @(negedge clk);
    check(idx == 6'd19, "R4 back to hw", idx, 19);

    // R6 power-down role
    pd_pin = 1'b0;
    @(negedge clk);
    check(pwrdn == 1'b1, "R6 pwrdn low pin", pwrdn, 1);
    pd_pin = 1'b1;
    @(negedge clk);
    check(pwrdn == 1'b0, "R6 pwrdn high pin", pwrdn, 0);
    quiet = 1'b1;
    for (int i = 0; i < 3 * W; i++) begin
      @(negedge clk);
      if (drv) quiet = 1'b0;
    end
    check(quiet, "R6 no reset drive", !quiet, 0);

    // R7 reset role: first timeout, R8 pulse length and next window
    power_up(5'd2, 1'b1, 1'b0, 1'b0);
    n = 1;
    pd_pin = 1'b0;
    while (!drv && n < 200) begin
      if (pwrdn) quiet = 1'b0;
      @(negedge clk);
      n++;
    end
    check(n == W + 2, "R7 first timeout", n, W + 2);
    check(pwrdn == 1'b0, "R7 no pwrdn", pwrdn, 0);
    n = 1;
    @(negedge clk);
    while (drv && n < 200) begin @(negedge clk); n++; end
    check(n == P, "R8 pulse width", n, P);
    n = 1;
    @(negedge clk);
    while (!drv && n < 200) begin @(negedge clk); n++; end
    check(n == W, "R8 window after pulse", n, W);
    pd_pin = 1'b1;

    // R9 kick reload timing
    power_up(5'd2, 1'b1, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    kick = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      kick = 1'b0;
      n++;
    end while (!drv && n < 200);
    check(n == W + 1, "R9 reload then timeout", n, W + 1);

    // R9 periodic kicks prevent pulses
    power_up(5'd2, 1'b1, 1'b0, 1'b0);
    quiet = 1'b1;
    for (int k = 0; k < 8; k++) begin
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      for (int i = 0; i < W - 2; i++) begin
        @(negedge clk);
        if (drv) quiet = 1'b0;
      end
    end
    check(quiet, "R9 kicks hold off", !quiet, 0);

    finish_run();
  end
endmodule